// File: doc/BRIEF.md
# Periodic Tick Rearm Engine

This block runs each time a periodic tick interrupt is serviced. It works out how many tick periods have gone by since the tick that was due, and places the next compare value back on a fixed grid of `P` counter cycles, so that late service does not make the tick phase drift. Its inputs are the free-running counter, the tick time that was due, and the period. It produces the elapsed tick count, the new due time (which the caller keeps and passes back as `expected_i` on the next service), and one or two writes of a 32-bit compare value.

Small lateness is handled by repeated subtraction of `P`, which takes at most 64 steps. Large lateness goes through a multi-cycle restoring divider. After the first compare write, the engine samples the counter again. If the new target has already slipped behind, it writes the compare value one period later. It also raises a flag when more than one second's worth of ticks has passed, and another when the rewrite sequence took too many counter cycles. A separate arm command sets up the first tick.

Top module: `tick_rearm`

## Requirements
- R1: After reset `busy_o`, `done_o`, `cmp_we_o`, `delayed_o` and `slow_o` are all 0.
- R2: An arm pulse in idle sets `next_o` to `counter_i + P` and `ticks_o` to 0, and clears both flags. In the cycle after the arm, `done_o` and `cmp_we_o` are 1, and `cmp_o` carries the low 32 bits of `next_o`. An arm makes exactly one compare write.
- R3: A start pulse in idle captures `now = counter_i` and computes `E = counter_i - expected_i` modulo 2^64. The tick count begins at 1. If `(E >> 6) < P`, a remainder starts at `E` and is reduced by `P` while it is strictly greater than `P`, with 1 added to the count for each reduction. The remainder can therefore end equal to `P`.
- R4: If `(E >> 6) >= P`, the tick count is `1 + E / P` and the remainder is `E mod P`.
- R5: The new due time is `now + (P - remainder)`. It is reported on `next_o` with the count on `ticks_o`. The first compare write carries its low 32 bits.
- R6: The counter is sampled again at the clock edge that ends the cycle in which the first compare write is visible. If `next_o` minus that sample, taken as unsigned 64-bit, exceeds `P`, a second compare write carries the low 32 bits of `next_o + P` in the same cycle as `done_o`. Otherwise there is no second write. `next_o` is unchanged either way.
- R7: `delayed_o` is 1 after a service exactly when `ticks_o` exceeds `TICK_RATE` (default 100).
- R8: `slow_o` is 1 after a service exactly when the second counter sample minus `now` exceeds `SLOW_LIMIT` (default 0x3000).
- R9: While `busy_o` is 1, `start_i` and `arm_i` are ignored. In idle, an arm takes priority over a simultaneous start.
- R10: `done_o` is a one-cycle pulse that is asserted only with `busy_o` low. Results and flags hold until the next arm or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Set up the first tick one period ahead |
| start_i | input | 1 | Begin a service computation |
| expected_i | input | 64 | Tick time that was due |
| counter_i | input | 64 | Live free-running counter |
| period_i | input | 32 | Tick period P in cycles, nonzero |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Results valid pulse |
| ticks_o | output | 64 | Elapsed tick count |
| next_o | output | 64 | New due tick time |
| cmp_o | output | 32 | Compare value to program |
| cmp_we_o | output | 1 | Compare write strobe |
| delayed_o | output | 1 | More than TICK_RATE ticks elapsed |
| slow_o | output | 1 | Rewrite took longer than SLOW_LIMIT cycles |

## Verification
A stale remainder or a wrongly selected path shows up in `next_o`, and in the first compare write, at the end of the same service. The case where the remainder equals `P` is the sharpest probe: a divider-style result moves the due time a full period away from the stepping result. A wrong recheck decision appears one cycle after the first write, as a missing or extra second strobe next to `done_o`. Wrap of the counter, and an expected time lying in the future, both show up as wrong tick counts on the very next service.

// File: rtl/tick_rearm_pkg.sv
package tick_rearm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_DIV  = 2'd2,
      ST_CHK  = 2'd3
   } rearm_state_t;

   // Short path entry guarantees value <= 64*P - 1, so at most 63 reductions.
   localparam int unsigned STEP_SHIFT = 6;
   localparam int unsigned MAX_STEPS  = 1 << STEP_SHIFT;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
   parameter int unsigned DVD_W = 64,
   parameter int unsigned DVS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DVD_W-1:0] dividend_i,
   input  logic [DVS_W-1:0] divisor_i,
   output logic             done_o,
   output logic [DVD_W-1:0] quot_o,
   output logic [DVS_W-1:0] rem_o
);
   localparam int unsigned CW = $clog2(DVD_W + 1);

   initial begin
      assert (DVD_W >= 2 && DVS_W >= 1 && DVS_W <= DVD_W)
         else $fatal(1, "tick_div: bad widths");
   end

   logic [DVD_W-1:0] dvd_q;
   logic [DVS_W-1:0] rem_q;
   logic [DVS_W-1:0] dvs_q;
   logic [CW-1:0]    cnt_q;
   logic             run_q;
   logic             done_q;

   logic [DVS_W:0]   trial;
   logic             fits;
   logic [DVS_W:0]   diff;

   always_comb begin
      trial = {rem_q, dvd_q[DVD_W-1]};
      fits  = (trial >= {1'b0, dvs_q});
      diff  = trial - {1'b0, dvs_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvd_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !run_q) begin
            dvd_q <= dividend_i;
            rem_q <= '0;
            dvs_q <= divisor_i;
            cnt_q <= CW'(DVD_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            dvd_q <= {dvd_q[DVD_W-2:0], fits};
            rem_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quot_o = dvd_q;
   assign rem_o  = rem_q;

   // R4: a finished division leaves a remainder below a nonzero divisor
   a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/tick_step.sv
module tick_step
   import tick_rearm_pkg::*;
#(
   parameter int unsigned VAL_W = 64,
   parameter int unsigned PER_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VAL_W-1:0] value_i,
   input  logic [PER_W-1:0] period_i,
   output logic             done_o,
   output logic [VAL_W-1:0] rem_o,
   output logic [$clog2(MAX_STEPS+1)-1:0] steps_o
);
   localparam int unsigned SW = $clog2(MAX_STEPS + 1);

   initial begin
      assert (PER_W + STEP_SHIFT <= VAL_W)
         else $fatal(1, "tick_step: value too narrow for period");
   end

   logic [VAL_W-1:0] rem_q;
   logic [VAL_W-1:0] per_q;
   logic [SW-1:0]    cnt_q;
   logic             run_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         per_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !run_q) begin
            rem_q <= value_i;
            per_q <= {{(VAL_W-PER_W){1'b0}}, period_i};
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (rem_q > per_q) begin
               rem_q <= rem_q - per_q;
               cnt_q <= cnt_q + SW'(1);
            end else begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o  = done_q;
   assign rem_o   = rem_q;
   assign steps_o = cnt_q;

   // R3: the entry condition bounds the loop; it never reaches MAX_STEPS
   a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q < SW'(MAX_STEPS)));
endmodule

// File: rtl/tick_rearm.sv
module tick_rearm
   import tick_rearm_pkg::*;
#(
   parameter int unsigned CNT_W       = 64,
   parameter int unsigned CMP_W       = 32,
   parameter int unsigned PER_W       = 32,
   parameter int unsigned TICK_RATE   = 100,
   parameter int unsigned SLOW_LIMIT  = 32'h3000,
   parameter bit          USE_STEPPER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] expected_i,
   input  logic [CNT_W-1:0] counter_i,
   input  logic [PER_W-1:0] period_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [CNT_W-1:0] ticks_o,
   output logic [CNT_W-1:0] next_o,
   output logic [CMP_W-1:0] cmp_o,
   output logic             cmp_we_o,
   output logic             delayed_o,
   output logic             slow_o
);
   localparam int unsigned SW = $clog2(MAX_STEPS + 1);
   localparam logic [CNT_W-1:0] RATE_LIM = CNT_W'(TICK_RATE);
   localparam logic [CNT_W-1:0] LAG_LIM  = CNT_W'(SLOW_LIMIT);

   initial begin
      assert (CMP_W >= 1 && CMP_W <= CNT_W)
         else $fatal(1, "tick_rearm: compare wider than counter");
      assert (PER_W + STEP_SHIFT <= CNT_W)
         else $fatal(1, "tick_rearm: period too wide for counter");
      assert (TICK_RATE > 0)
         else $fatal(1, "tick_rearm: tick rate must be nonzero");
   end

   rearm_state_t     state_q;
   logic [CNT_W-1:0] now_q;
   logic [PER_W-1:0] per_q;
   logic [CNT_W-1:0] next_q;
   logic [CNT_W-1:0] ticks_q;
   logic [CMP_W-1:0] cmp_q;
   logic             we_q;
   logic             done_q;
   logic             dly_q;
   logic             slow_q;

   logic [CNT_W-1:0] per_in_ext;
   logic [CNT_W-1:0] per_ext_q;
   logic [CNT_W-1:0] elapsed;
   logic             short_path;
   logic             fire;

   assign per_in_ext = {{(CNT_W-PER_W){1'b0}}, period_i};
   assign per_ext_q  = {{(CNT_W-PER_W){1'b0}}, per_q};
   assign elapsed    = counter_i - expected_i;
   assign fire       = (state_q == ST_IDLE) && start_i && !arm_i;

   // ---------------- engines ----------------
   logic             step_done;
   logic [CNT_W-1:0] step_rem;
   logic [SW-1:0]    step_cnt;
   logic             div_done;
   logic [CNT_W-1:0] div_quot;
   logic [PER_W-1:0] div_rem;

   generate
      if (USE_STEPPER) begin : g_step
         assign short_path = ((elapsed >> STEP_SHIFT) < per_in_ext);
         tick_step #(.VAL_W(CNT_W), .PER_W(PER_W)) u_step (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (fire && short_path),
            .value_i  (elapsed),
            .period_i (period_i),
            .done_o   (step_done),
            .rem_o    (step_rem),
            .steps_o  (step_cnt)
         );
      end else begin : g_nostep
         assign short_path = 1'b0;
         assign step_done  = 1'b0;
         assign step_rem   = '0;
         assign step_cnt   = '0;
      end
   endgenerate

   tick_div #(.DVD_W(CNT_W), .DVS_W(PER_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (fire && !short_path),
      .dividend_i (elapsed),
      .divisor_i  (period_i),
      .done_o     (div_done),
      .quot_o     (div_quot),
      .rem_o      (div_rem)
   );

   // ---------------- result merge ----------------
   logic             eng_done;
   logic [CNT_W-1:0] eng_rem;
   logic [CNT_W-1:0] eng_quot;
   logic [CNT_W-1:0] next_calc;
   logic [CNT_W-1:0] gap;
   logic [CNT_W-1:0] lag;

   always_comb begin
      eng_done  = (state_q == ST_STEP) ? step_done : div_done;
      eng_rem   = (state_q == ST_STEP) ? step_rem
                                       : {{(CNT_W-PER_W){1'b0}}, div_rem};
      eng_quot  = (state_q == ST_STEP) ? {{(CNT_W-SW){1'b0}}, step_cnt}
                                       : div_quot;
      next_calc = now_q + (per_ext_q - eng_rem);
      gap       = next_q - counter_i;
      lag       = counter_i - now_q;
   end

   // ---------------- control ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         now_q   <= '0;
         per_q   <= '0;
         next_q  <= '0;
         ticks_q <= '0;
         cmp_q   <= '0;
         we_q    <= 1'b0;
         done_q  <= 1'b0;
         dly_q   <= 1'b0;
         slow_q  <= 1'b0;
      end else begin
         we_q   <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (arm_i) begin
                  next_q  <= counter_i + per_in_ext;
                  cmp_q   <= CMP_W'(counter_i + per_in_ext);
                  ticks_q <= '0;
                  dly_q   <= 1'b0;
                  slow_q  <= 1'b0;
                  we_q    <= 1'b1;
                  done_q  <= 1'b1;
               end else if (start_i) begin
                  now_q   <= counter_i;
                  per_q   <= period_i;
                  state_q <= short_path ? ST_STEP : ST_DIV;
               end
            end
            ST_STEP, ST_DIV: begin
               if (eng_done) begin
                  ticks_q <= CNT_W'(1) + eng_quot;
                  next_q  <= next_calc;
                  cmp_q   <= next_calc[CMP_W-1:0];
                  we_q    <= 1'b1;
                  state_q <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (gap > per_ext_q) begin
                  cmp_q <= CMP_W'(next_q + per_ext_q);
                  we_q  <= 1'b1;
               end
               dly_q   <= (ticks_q > RATE_LIM);
               slow_q  <= (lag > LAG_LIM);
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign ticks_o   = ticks_q;
   assign next_o    = next_q;
   assign cmp_o     = cmp_q;
   assign cmp_we_o  = we_q;
   assign delayed_o = dly_q;
   assign slow_o    = slow_q;

   // R5: the computed due time sits at most one period past the captured counter
   a_r5_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHK) |-> ((next_q - now_q) <= per_ext_q));

   // R6: two back-to-back writes only happen as the recheck closing a service
   a_r6_rewrite_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_we_o && $past(cmp_we_o)) |-> done_o);

   // R10: completion is only signalled with the engine idle
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9: a busy engine is not pulled back to idle by new requests
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && state_q != ST_CHK) |=> busy_o);

   // R2: an arm completes in one cycle with exactly one write and zero ticks
   a_r2_arm_single: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && arm_i) |=> (done_o && cmp_we_o && ticks_o == '0));
endmodule

// File: tb/tb_tick_rearm.sv
module tb_tick_rearm;
   localparam int unsigned RATE = 100;
   localparam longint unsigned LAGL = 64'h3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm_i = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] expected_i = '0;
   logic [63:0] counter_i = '0;
   logic [31:0] period_i = 32'd1;
   logic        busy_o, done_o, cmp_we_o, delayed_o, slow_o;
   logic [63:0] ticks_o, next_o;
   logic [31:0] cmp_o;

   int checks = 0;
   int fails  = 0;

   tick_rearm dut (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .start_i(start_i),
      .expected_i(expected_i), .counter_i(counter_i), .period_i(period_i),
      .busy_o(busy_o), .done_o(done_o), .ticks_o(ticks_o), .next_o(next_o),
      .cmp_o(cmp_o), .cmp_we_o(cmp_we_o), .delayed_o(delayed_o), .slow_o(slow_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void model(input longint unsigned e, input longint unsigned n,
                                 input longint unsigned p, input longint unsigned n2,
                                 output longint unsigned t, output longint unsigned nx,
                                 output bit rw, output bit dl, output bit sl);
      longint unsigned el, r;
      el = n - e;
      t  = 1;
      if ((el >> 6) < p) begin
         r = el;
         while (r > p) begin r -= p; t++; end
      end else begin
         t += el / p;
         r  = el % p;
      end
      nx = n + (p - r);
      rw = ((nx - n2) > p);
      dl = (t > RATE);
      sl = ((n2 - n) > LAGL);
   endfunction

   task automatic service(input longint unsigned e, input longint unsigned n,
                          input int unsigned p, input longint unsigned n2, input bit poke);
      longint unsigned t, nx, pp;
      bit rw, dl, sl, fin;
      int nw, cyc;
      logic [31:0] w0, w1;
      pp = 64'(p);
      model(e, n, pp, n2, t, nx, rw, dl, sl);
      @(negedge clk);
      expected_i = e; counter_i = n; period_i = p; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      nw = 0; cyc = 0; fin = 1'b0; w0 = '0; w1 = '0;
      while (!fin && cyc < 400) begin
         arm_i = 1'b0; start_i = 1'b0;
         if (poke && cyc == 0) begin
            arm_i = 1'b1; start_i = 1'b1; expected_i = ~e;
         end
         if (cmp_we_o) begin
            if (nw == 0) begin w0 = cmp_o; counter_i = n2; end
            else w1 = cmp_o;
            nw++;
         end
         if (done_o) fin = 1'b1;
         else begin @(negedge clk); cyc++; end
      end
      arm_i = 1'b0; start_i = 1'b0;
      chk("R10 done seen", 64'(fin), 64'd1);
      chk("R3/R4 ticks", ticks_o, t);
      chk("R5 next", next_o, nx);
      chk("R5 first write", 64'(w0), 64'(nx[31:0]));
      chk("R6 write count", 64'(nw), rw ? 64'd2 : 64'd1);
      if (rw) chk("R6 rewrite value", 64'(w1), 64'(32'(nx + pp)));
      chk("R7 delayed", 64'(delayed_o), 64'(dl));
      chk("R8 slow", 64'(slow_o), 64'(sl));
      @(negedge clk);
      chk("R10 done pulse", 64'(done_o), 64'd0);
      chk("R10 held next", next_o, nx);
   endtask

   task automatic arm(input longint unsigned n, input int unsigned p, input bit also_start);
      int nw, cyc;
      bit fin;
      logic [31:0] w0;
      @(negedge clk);
      counter_i = n; period_i = p; expected_i = n; arm_i = 1'b1; start_i = also_start;
      @(negedge clk);
      arm_i = 1'b0; start_i = 1'b0;
      nw = 0; cyc = 0; fin = 1'b0; w0 = '0;
      while (!fin && cyc < 10) begin
         if (cmp_we_o) begin w0 = cmp_o; nw++; end
         if (done_o) fin = 1'b1;
         else begin @(negedge clk); cyc++; end
      end
      chk("R2 done next cycle", 64'(cyc), 64'd0);
      chk("R2 ticks zero", ticks_o, 64'd0);
      chk("R2 next", next_o, n + 64'(p));
      chk("R2 write value", 64'(w0), 64'(32'(n + 64'(p))));
      chk("R2 one write", 64'(nw), 64'd1);
      chk("R2 flags clear", 64'({delayed_o, slow_o}), 64'd0);
      @(negedge clk);
      chk("R9 arm wins, not busy", 64'(busy_o), 64'd0);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      longint unsigned n, p64, el;
      int unsigned p;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 64'(busy_o), 64'd0);
      chk("R1 done", 64'(done_o), 64'd0);
      chk("R1 we", 64'(cmp_we_o), 64'd0);
      chk("R1 flags", 64'({delayed_o, slow_o}), 64'd0);
      rst_n = 1'b1;

      arm(64'd1000, 500, 1'b0);
      arm(64'h0000_0001_FFFF_FF00, 32'h200, 1'b1);      // R2 with 32-bit wrap, R9 arm over start

      n = 64'h1_0000_0000;
      service(n, n, 1000, n + 3, 1'b0);                  // R3 on time
      service(n - 3007, n, 1000, n + 3, 1'b0);            // R3 three reductions
      service(n - 1000, n, 1000, n + 4, 1'b0);            // R3 remainder equals P, R6 rewrite
      service(n - 2000, n, 1000, n + 4, 1'b0);            // R3 stop at P after one step
      service(n - 64000, n, 1000, n + 10, 1'b0);          // R4 boundary (E>>6 == P)
      service(n - 63999, n, 1000, n + 10, 1'b0);          // R3 just under boundary
      service(n - 99000, n, 1000, n + 2, 1'b0);           // R7 exactly 100 ticks
      service(n - 100000, n, 1000, n + 2, 1'b0);          // R7 101 ticks delayed
      service(n - 1000003, n, 1000, n + 2, 1'b0);         // R7 large lateness
      service(n - 5, n, 1000, n + 64'h3000, 1'b0);        // R8 at limit
      service(n - 5, n, 1000, n + 64'h3001, 1'b0);        // R8 over limit
      service(64'hFFFF_FFFF_FFFF_FF00, 64'h40, 300, 64'h48, 1'b0); // R3 counter wrap
      service(n + 50, n, 1000, n + 1, 1'b0);             // R4 expected in the future
      service(n - 200000, n, 1000, n + 7, 1'b1);          // R9 requests ignored while busy

      for (int i = 0; i < 60; i++) begin
         p   = 1 + ($urandom % 32'h10000);
         p64 = 64'(p);
         n   = {32'($urandom), 32'($urandom)};
         case ($urandom % 4)
            0: el = 64'($urandom) % (p64 * 64);
            1: el = p64 * (64'($urandom % 3000)) + 64'($urandom) % p64;
            2: el = {32'($urandom), 32'($urandom)};
            default: el = p64 * 64 + 64'($urandom % 8);
         endcase
         service(n - el, n, p, n + 64'($urandom % 32'h3100) + p64 * 64'($urandom % 2), 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule